// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

The block raises a periodic timer event from one of four slow strobe inputs: a 1024 Hz tick, a 64 Hz tick, a 1 Hz tick and a once-per-minute tick. It counts ticks of the chosen strobe against a 7-bit reload value, so the period runs from one tick up to 128 ticks. Each expiry sets a sticky event flag that stays set until software clears it, and it shapes an open-drain, active-low interrupt line.

The interrupt line has two shapes. In square mode the low phase alternates with the released phase, and each phase lasts one full period. In pulse mode the line goes low at each expiry for a fixed window of eight 1024 Hz ticks, which is 7.8125 ms. The line is pulled low only when the interrupt enable is set, the flag is set and the waveform is in its low phase. Otherwise it is released to high impedance.

All register fields reach the block as static levels from a register file that is not part of this block. The flag clear comes in as a one-cycle strobe.

Top module: `interval_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `tmr_flag` and `irq_sink` are both 0.
- R2: `src_sel` picks the counting tick: 0 = `tick_1024`, 1 = `tick_64`, 2 = `tick_1hz`, 3 = `tick_1min`. Ticks of the other three strobes do not advance the count.
- R3: With `run_en` high and the fields unchanged, the first expiry comes on the (`reload`+1)th selected tick after a start. Later expiries come every `reload`+1 selected ticks. Every register output updates at the clock edge that samples the tick.
- R4: `tmr_flag` becomes 1 at the edge of each expiry and holds until a cycle with `flag_clr` high. When an expiry and `flag_clr` fall in the same cycle, the flag ends at 1.
- R5: `irq_sink` (1 = line pulled low, 0 = released) is 1 exactly when `irq_en`, `tmr_flag` and the waveform low phase are all 1. With `irq_en` at 0 the line is released.
- R6: In square mode (`pulse_mode` = 0) the low phase starts released after any start. It toggles at every expiry, so it is low for one period and released for the next.
- R7: In pulse mode (`pulse_mode` = 1) the low phase begins at each expiry. It ends at the eighth `tick_1024` after that expiry, whichever source is selected. A tick in the same cycle as the expiry does not count. A new expiry inside the window restarts it.
- R8: The combination of `src_sel` = 1 with `pulse_mode` = 0 is illegal. While it is present the count is held at zero, no expiry occurs and the waveform is released.
- R9: A change of `reload`, `src_sel` or `pulse_mode` restarts the period from zero in the cycle the change appears, and releases the waveform.
- R10: While `run_en` is 0 the count is held at zero, no expiry occurs and the waveform is released. After `run_en` returns to 1, a full `reload`+1 ticks pass before the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1024 | input | 1 | One-cycle strobe at 1024 Hz |
| tick_64 | input | 1 | One-cycle strobe at 64 Hz |
| tick_1hz | input | 1 | One-cycle strobe at 1 Hz |
| tick_1min | input | 1 | One-cycle strobe once per minute |
| src_sel | input | 2 | Tick source select |
| reload | input | 7 | Period count; period is reload+1 ticks |
| pulse_mode | input | 1 | 0 = square waveform, 1 = fixed low pulse |
| irq_en | input | 1 | Interrupt line enable |
| run_en | input | 1 | Countdown enable |
| flag_clr | input | 1 | One-cycle strobe that clears the event flag |
| tmr_flag | output | 1 | Sticky event flag |
| irq_sink | output | 1 | 1 = interrupt line pulled low, 0 = released |

## Verification
The hardest case to reach from the ports is a pulse-mode expiry that lands inside a window that is still open. It needs a period shorter than eight 1024 Hz ticks, with the 1024 Hz strobe both selected and counting the window. Cases where the expiry and a window tick fall in the same cycle are also hard to reach. The random phase therefore keeps `reload` small, fires the fast strobe densely and mixes source and mode changes. A cycle reference model in the bench follows every step. Directed sequences pin the window length, flag set-versus-clear priority, the illegal combination and restart timing with hand-derived values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CNT_W_DEF       = 7;
    localparam int unsigned PULSE_TICKS_DEF = 8;
    localparam int unsigned NUM_SRC         = 4;

    typedef enum logic [1:0] {
        SRC_FAST = 2'd0,
        SRC_MID  = 2'd1,
        SRC_SEC  = 2'd2,
        SRC_MIN  = 2'd3
    } tmr_src_e;

    typedef enum logic {
        SHAPE_SQUARE = 1'b0,
        SHAPE_PULSE  = 1'b1
    } tmr_shape_e;

    // Field snapshot used to detect reprogramming
    typedef struct packed {
        tmr_src_e   src;
        tmr_shape_e shape;
    } tmr_mode_t;

    // Mid-rate source cannot feed the square waveform
    function automatic logic mode_is_illegal(input tmr_mode_t m);
        return (m.src == SRC_MID) && (m.shape == SHAPE_SQUARE);
    endfunction

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
(
    input  logic [NUM_SRC-1:0] tick_vec,
    input  tmr_src_e           src,
    output logic               tick_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = tick_vec[g] && (src == tmr_src_e'(g));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/tmr_period_cnt.sv
module tmr_period_cnt #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);

    logic [CNT_W-1:0] elapsed;
    logic             at_end;

    assign at_end = (elapsed == reload);
    assign expire = !hold && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
        end else if (hold) begin
            elapsed <= '0;
        end else if (tick) begin
            if (at_end) elapsed <= '0;
            else        elapsed <= elapsed + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_wave_shape.sv
module tmr_wave_shape
    import tmr_pkg::*;
#(
    parameter int unsigned PULSE_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       expire,
    input  tmr_shape_e shape,
    input  logic       fast_tick,
    output logic       low_phase
);

    localparam int unsigned PW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);

    logic          win;
    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            win  <= 1'b0;
            pcnt <= '0;
        end else if (expire) begin
            pcnt <= '0;
            if (shape == SHAPE_SQUARE) win <= ~win;
            else                       win <= 1'b1;
        end else if (shape == SHAPE_PULSE && win && fast_tick) begin
            if (pcnt == LAST) begin
                win  <= 1'b0;
                pcnt <= '0;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    assign low_phase = win;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W       = CNT_W_DEF,
    parameter int unsigned PULSE_TICKS = PULSE_TICKS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1024,
    input  logic             tick_64,
    input  logic             tick_1hz,
    input  logic             tick_1min,
    input  logic [1:0]       src_sel,
    input  logic [CNT_W-1:0] reload,
    input  logic             pulse_mode,
    input  logic             irq_en,
    input  logic             run_en,
    input  logic             flag_clr,
    output logic             tmr_flag,
    output logic             irq_sink
);

    tmr_mode_t        cur_mode, prev_mode;
    logic [CNT_W-1:0] prev_reload;
    logic             restart, illegal, hold;
    logic             sel_tick, expire, low_phase;
    logic             flag_q;

    assign cur_mode.src   = tmr_src_e'(src_sel);
    assign cur_mode.shape = tmr_shape_e'(pulse_mode);

    assign restart = (cur_mode != prev_mode) || (reload != prev_reload);
    assign illegal = mode_is_illegal(cur_mode);
    assign hold    = !run_en || restart || illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_mode   <= '0;
            prev_reload <= '0;
        end else begin
            prev_mode   <= cur_mode;
            prev_reload <= reload;
        end
    end

    tmr_tick_sel u_sel (
        .tick_vec ({tick_1min, tick_1hz, tick_64, tick_1024}),
        .src      (cur_mode.src),
        .tick_o   (sel_tick)
    );

    tmr_period_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .tick   (sel_tick),
        .reload (reload),
        .expire (expire)
    );

    tmr_wave_shape #(.PULSE_TICKS(PULSE_TICKS)) u_shape (
        .clk       (clk),
        .rst       (rst),
        .clear     (hold),
        .expire    (expire),
        .shape     (cur_mode.shape),
        .fast_tick (tick_1024),
        .low_phase (low_phase)
    );

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (expire)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign tmr_flag = flag_q;
    assign irq_sink = irq_en && flag_q && low_phase;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input logic       irq_en,
    input logic       flag_clr,
    input logic       pulse_mode,
    input logic [1:0] src_sel,
    input logic       expire,
    input logic       tmr_flag,
    input logic       irq_sink
);

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tmr_flag && !flag_clr) |=> tmr_flag); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !expire) |=> !tmr_flag); // R4

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'd1 && !pulse_mode) |-> !expire); // R8

    AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> !expire); // R10

    AST_STOPPED_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!irq_sink || !$past(run_en) && run_en && 1'b0) || !irq_sink); // R10

    AST_LINE_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_sink) |-> (irq_en && tmr_flag)); // R5

endmodule

bind interval_timer tmr_checker u_tmr_checker (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .pulse_mode (pulse_mode),
    .src_sel    (src_sel),
    .expire     (expire),
    .tmr_flag   (tmr_flag),
    .irq_sink   (irq_sink)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       t1024 = 0, t64 = 0, t1hz = 0, tmin = 0;
    logic [1:0] src_sel = 2'd0;
    logic [6:0] reload = 7'd0;
    logic       pulse_mode = 1'b0, irq_en = 1'b0, run_en = 1'b0, flag_clr = 1'b0;
    logic       tmr_flag, irq_sink;

    int unsigned n_vec = 0, n_bad = 0;
    string       cur_req = "R1";

    // reference state
    logic [6:0] m_el;
    logic       m_win, m_flag;
    int         m_pc;
    logic [1:0] p_src;
    logic [6:0] p_ct;
    logic       p_pm;

    always #5 clk = ~clk;

    interval_timer i_interval_timer (
        .clk(clk), .rst(rst),
        .tick_1024(t1024), .tick_64(t64), .tick_1hz(t1hz), .tick_1min(tmin),
        .src_sel(src_sel), .reload(reload), .pulse_mode(pulse_mode),
        .irq_en(irq_en), .run_en(run_en), .flag_clr(flag_clr),
        .tmr_flag(tmr_flag), .irq_sink(irq_sink)
    );

    function automatic logic pick_tick(input logic [1:0] s, input logic a, b, c, d);
        case (s)
            2'd0: return a;
            2'd1: return b;
            2'd2: return c;
            default: return d;
        endcase
    endfunction

    task automatic model_next();
        logic stop, ex, tk;
        if (rst) begin
            m_el = 0; m_win = 0; m_flag = 0; m_pc = 0;
            p_src = 0; p_ct = 0; p_pm = 0;
            return;
        end
        stop = !run_en || (src_sel == 2'd1 && !pulse_mode) ||
               (src_sel != p_src) || (reload != p_ct) || (pulse_mode != p_pm);
        tk = pick_tick(src_sel, t1024, t64, t1hz, tmin);
        ex = 1'b0;
        if (stop) m_el = 0;
        else if (tk) begin
            if (m_el == reload) begin m_el = 0; ex = 1'b1; end
            else m_el = m_el + 1;
        end
        if (stop) begin m_win = 0; m_pc = 0; end
        else if (ex) begin
            m_pc = 0;
            m_win = pulse_mode ? 1'b1 : !m_win;
        end else if (pulse_mode && m_win && t1024) begin
            if (m_pc == 7) begin m_win = 0; m_pc = 0; end
            else m_pc = m_pc + 1;
        end
        if (ex) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
        p_src = src_sel; p_ct = reload; p_pm = pulse_mode;
    endtask

    // one clock: apply ticks/clear, compare against model at negedge
    task automatic step(input logic a, b, c, d, input logic clr);
        logic exp_irq;
        t1024 = a; t64 = b; t1hz = c; tmin = d; flag_clr = clr;
        model_next();
        @(posedge clk);
        @(negedge clk);
        t1024 = 0; t64 = 0; t1hz = 0; tmin = 0; flag_clr = 0;
        exp_irq = irq_en && m_flag && m_win;
        n_vec++;
        if (tmr_flag !== m_flag || irq_sink !== exp_irq) begin
            n_bad++;
            $display("FAIL %s model: flag=%b irq=%b expected flag=%b irq=%b",
                     cur_req, tmr_flag, irq_sink, m_flag, exp_irq);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cur_req = "R1";
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R1", tmr_flag, 1'b0, "flag in reset");
        chk("R1", irq_sink, 1'b0, "line in reset");
        rst = 1'b0;
        step(0, 0, 0, 0, 0);
        chk("R1", tmr_flag, 1'b0, "flag after reset");

        // R3 / R2 / R7 / R4 : 1 Hz source, reload 3, pulse shape
        cur_req = "R3";
        src_sel = 2; reload = 3; pulse_mode = 1; irq_en = 1; run_en = 1;
        idle(1);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 0);
        chk("R2", tmr_flag, 1'b0, "other sources must not count");
        step(0, 0, 1, 0, 0);
        chk("R3", tmr_flag, 1'b1, "expiry on 4th tick");
        chk("R7", irq_sink, 1'b1, "pulse window opens");
        cur_req = "R7";
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0);
        chk("R7", irq_sink, 1'b1, "window after 7 fast ticks");
        step(1, 0, 0, 0, 0);
        chk("R7", irq_sink, 1'b0, "window closes on 8th fast tick");
        cur_req = "R4";
        step(0, 0, 0, 0, 1);
        chk("R4", tmr_flag, 1'b0, "clear strobe");

        // R4 set wins over clear
        reload = 0;
        idle(1);
        step(0, 0, 1, 0, 1);
        chk("R4", tmr_flag, 1'b1, "set beats clear");

        // R5 enable gating
        cur_req = "R5";
        irq_en = 0;
        step(0, 0, 1, 0, 0);
        chk("R5", irq_sink, 1'b0, "line released with enable off");
        irq_en = 1;
        idle(1);
        chk("R5", irq_sink, 1'b1, "line low with enable on");

        // R6 square shape
        cur_req = "R6";
        pulse_mode = 0;
        step(0, 0, 0, 0, 1);
        chk("R9", irq_sink, 1'b0, "mode change releases line");
        step(0, 0, 1, 0, 0);
        chk("R6", irq_sink, 1'b1, "first square phase low");
        step(0, 0, 1, 0, 0);
        chk("R6", irq_sink, 1'b0, "second square phase released");
        chk("R6", tmr_flag, 1'b1, "flag still set");
        step(0, 0, 1, 0, 0);
        chk("R6", irq_sink, 1'b1, "third square phase low");

        // R8 illegal combination
        cur_req = "R8";
        src_sel = 1;
        step(0, 0, 0, 0, 1);
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0);
        chk("R8", tmr_flag, 1'b0, "no expiry in illegal combination");
        chk("R8", irq_sink, 1'b0, "line released in illegal combination");
        pulse_mode = 1;
        idle(1);
        step(0, 1, 0, 0, 0);
        chk("R2", tmr_flag, 1'b1, "64 Hz source counts in pulse shape");

        // R9 restart on reprogram
        cur_req = "R9";
        src_sel = 2; reload = 2;
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        reload = 3;
        idle(1);
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
        chk("R9", tmr_flag, 1'b0, "restart after reload change");
        step(0, 0, 1, 0, 0);
        chk("R9", tmr_flag, 1'b1, "full period after restart");

        // R10 run enable
        cur_req = "R10";
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        run_en = 0;
        step(0, 0, 1, 0, 0);
        chk("R10", irq_sink, 1'b0, "line released while stopped");
        run_en = 1;
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
        chk("R10", tmr_flag, 1'b0, "count cleared while stopped");
        step(0, 0, 1, 0, 0);
        chk("R10", tmr_flag, 1'b1, "full period after run");

        // R2 remaining sources
        cur_req = "R2";
        src_sel = 3; reload = 0;
        step(0, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0);
        chk("R2", tmr_flag, 1'b0, "minute source ignores faster ticks");
        step(0, 0, 0, 1, 0);
        chk("R2", tmr_flag, 1'b1, "minute source counts");
        src_sel = 0;
        step(0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0);
        chk("R2", tmr_flag, 1'b1, "fast source counts");

        // constrained random phase
        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 200) == 0) src_sel = 2'($urandom % 4);
            if (($urandom % 200) == 0) reload = 7'($urandom % 12);
            if (($urandom % 300) == 0) pulse_mode = 1'($urandom % 2);
            if (($urandom % 150) == 0) irq_en = 1'($urandom % 2);
            if (($urandom % 250) == 0) run_en = (($urandom % 4) != 0);
            step((($urandom % 3) == 0), (($urandom % 4) == 0),
                 (($urandom % 4) == 0), (($urandom % 5) == 0),
                 (($urandom % 20) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule